// File: doc/BRIEF.md
# Parallel I/Q Pair Assembler

The block receives baseband samples on a single parallel bus, one word per core clock cycle. Each I/Q pair arrives as two words in a row. The block joins each two-word pair into one I/Q output word with a one-cycle valid strobe. Input words in offset-binary coding are converted to two's complement. The block also drives a port clock that tells the source which half of the pair the bus should carry.

A transmit-enable input, with selectable polarity, gates the whole flow. In standby the bus is ignored. The baseband output then either drops to zero or keeps the last complete pair, depending on a configuration input.

Configuration inputs select:
- the word order (I first or Q first),
- the coding of the input words,
- the polarity of the port clock,
- whether the port clock is driven at all,
- the transmit-enable polarity,
- the standby behaviour.

All configuration inputs are sampled only at pair boundaries. A pair is therefore never split across two settings.

Top module: `iq_pair_assembler`

## Requirements
- R1: When `cfgQFirst` is 0, the first word of a pair is I and the second is Q. When `cfgQFirst` is 1, the first word is Q and the second is I.
- R2: When `cfgOffsetBin` is 1, bit 17 of each input word is inverted before it is stored. When `cfgOffsetBin` is 0, input words pass through unchanged, as two's complement.
- R3: `iOut`, `qOut` and `pairValid` update on the rising edge that samples the second word of a pair. `pairValid` is high for that one cycle only.
- R4: The internal phase is 0 while the first word is expected and 1 while the second word is expected. When `cfgClkInvert` is 0, `portClk` is 1 in the cycles where the bus should carry Q and 0 where it should carry I. When `cfgClkInvert` is 1, the levels are swapped.
- R5: When `cfgClkEnable` is 0, `portClk` stays at 0. Pair assembly continues unchanged.
- R6: Transmit is active when `txEnPin` XOR `cfgTxInvert` is 1.
- R7: While transmit is inactive:
  - bus data is ignored and `pairValid` stays 0;
  - when `cfgHoldLast` is 0, `iOut` and `qOut` go to 0;
  - when `cfgHoldLast` is 1, `iOut` and `qOut` keep the last complete pair.
- R8: The phase returns to "first word" whenever transmit is inactive. When transmit is dropped partway through a pair, the partial pair is discarded, and the word that arrives with the next activation is taken as a first word.
- R9: Configuration inputs take effect only at a pair boundary: either while transmit is inactive, or at the edge that completes a pair. A change made partway through a pair does not alter that pair.
- R10: After reset, `iOut`, `qOut` and `pairValid` are 0, and the phase expects a first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one bus word per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| busData | input | 18 | Parallel sample bus |
| txEnPin | input | 1 | Transmit enable, polarity set by cfgTxInvert |
| cfgQFirst | input | 1 | 1: Q word precedes I word |
| cfgOffsetBin | input | 1 | 1: input words are offset binary |
| cfgClkInvert | input | 1 | 1: invert port clock polarity |
| cfgClkEnable | input | 1 | 0: hold portClk at 0 |
| cfgTxInvert | input | 1 | 1: txEnPin low means transmit |
| cfgHoldLast | input | 1 | 1: keep last pair in standby, 0: force zeros |
| portClk | output | 1 | Port clock marking the expected half of the pair |
| iOut | output | 18 | Assembled I sample, two's complement |
| qOut | output | 18 | Assembled Q sample, two's complement |
| pairValid | output | 1 | One-cycle strobe for a new pair |

## Verification
The bench drops transmit after only the first word of a pair. A design that kept that word would pair it with the first word of the next burst and shift every later pair by one half. A second test flips the word order in the middle of a pair. A design without boundary latching would produce one pair whose halves are swapped or taken from two different pairs. The bench also runs every combination of order, coding, clock polarity, transmit polarity and standby mode, then toggles the bus during standby. This catches a wrong MSB flip, a port clock of the wrong sense, and outputs that follow the bus while idle.

// File: rtl/iq_asm_pkg.sv
package iq_asm_pkg;
  // Strobes and settings passed from control to datapath
  typedef struct packed {
    logic captureFirst;
    logic emitPair;
    logic zeroIdle;
    logic qFirst;
    logic offsetBin;
  } ctrlStrobes_t;
endpackage

// File: rtl/iq_asm_ctrl.sv
module iq_asm_ctrl
  import iq_asm_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         txEnPin,
  input  logic         cfgQFirst,
  input  logic         cfgOffsetBin,
  input  logic         cfgClkInvert,
  input  logic         cfgClkEnable,
  input  logic         cfgTxInvert,
  input  logic         cfgHoldLast,
  output ctrlStrobes_t strb,
  output logic         portClk,
  output logic         txActive
);
  logic phase;
  logic qFirstR, offR, clkInvR, clkEnR, txInvR, holdR;
  logic loadCfg;
  logic qOnBus;

  assign txActive = txEnPin ^ txInvR;
  // Pair boundary: idle, or the edge that takes the second word
  assign loadCfg  = ~txActive | phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      qFirstR <= 1'b0;
      offR    <= 1'b0;
      clkInvR <= 1'b0;
      clkEnR  <= 1'b1;
      txInvR  <= 1'b0;
      holdR   <= 1'b0;
    end else begin
      phase <= txActive & ~phase;
      if (loadCfg) begin
        qFirstR <= cfgQFirst;
        offR    <= cfgOffsetBin;
        clkInvR <= cfgClkInvert;
        clkEnR  <= cfgClkEnable;
        txInvR  <= cfgTxInvert;
        holdR   <= cfgHoldLast;
      end
    end
  end

  assign qOnBus  = qFirstR ? ~phase : phase;
  assign portClk = clkEnR & (qOnBus ^ clkInvR);

  always_comb begin
    strb.captureFirst = txActive & ~phase;
    strb.emitPair     = txActive & phase;
    strb.zeroIdle     = ~txActive & ~holdR;
    strb.qFirst       = qFirstR;
    strb.offsetBin    = offR;
  end
endmodule

// File: rtl/iq_asm_datapath.sv
module iq_asm_datapath
  import iq_asm_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] busData,
  input  ctrlStrobes_t      strb,
  output logic [DATA_W-1:0] iOut,
  output logic [DATA_W-1:0] qOut,
  output logic              pairValid
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] convWord;
  logic [DATA_W-1:0] firstWord;

  assign convWord = strb.offsetBin ? {~busData[MSB], busData[MSB-1:0]} : busData;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      firstWord <= '0;
      iOut      <= '0;
      qOut      <= '0;
      pairValid <= 1'b0;
    end else begin
      pairValid <= strb.emitPair;
      if (strb.captureFirst) firstWord <= convWord;
      if (strb.emitPair) begin
        iOut <= strb.qFirst ? convWord : firstWord;
        qOut <= strb.qFirst ? firstWord : convWord;
      end else if (strb.zeroIdle) begin
        iOut <= '0;
        qOut <= '0;
      end
    end
  end
endmodule

// File: rtl/iq_pair_assembler.sv
module iq_pair_assembler
  import iq_asm_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] busData,
  input  logic              txEnPin,
  input  logic              cfgQFirst,
  input  logic              cfgOffsetBin,
  input  logic              cfgClkInvert,
  input  logic              cfgClkEnable,
  input  logic              cfgTxInvert,
  input  logic              cfgHoldLast,
  output logic              portClk,
  output logic [DATA_W-1:0] iOut,
  output logic [DATA_W-1:0] qOut,
  output logic              pairValid
);
  ctrlStrobes_t strb;
  logic         txActive;

  iq_asm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .txEnPin(txEnPin),
    .cfgQFirst(cfgQFirst), .cfgOffsetBin(cfgOffsetBin),
    .cfgClkInvert(cfgClkInvert), .cfgClkEnable(cfgClkEnable),
    .cfgTxInvert(cfgTxInvert), .cfgHoldLast(cfgHoldLast),
    .strb(strb), .portClk(portClk), .txActive(txActive)
  );

  iq_asm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .busData(busData), .strb(strb),
    .iOut(iOut), .qOut(qOut), .pairValid(pairValid)
  );
endmodule

// File: rtl/iq_asm_checker.sv
module iq_asm_checker
  import iq_asm_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pairValid,
  input logic [DATA_W-1:0] iOut,
  input logic [DATA_W-1:0] qOut,
  input logic              portClk,
  input logic              cfgClkEnable,
  input logic              txActive,
  input ctrlStrobes_t      strb
);
  // R3
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pairValid |=> !pairValid);

  // R7
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txActive |=> !pairValid);

  // R7
  idle_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.zeroIdle |=> (iOut == '0) && (qOut == '0));

  // R8
  valid_needs_two_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pairValid |-> ($past(txActive) && $past(txActive, 2)));

  // R5
  clk_disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfgClkEnable) && !$past(cfgClkEnable, 2)) |-> !portClk);
endmodule

bind iq_pair_assembler iq_asm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pairValid(pairValid), .iOut(iOut), .qOut(qOut),
  .portClk(portClk), .cfgClkEnable(cfgClkEnable), .txActive(txActive), .strb(strb)
);

// File: tb/iq_pair_assembler_tb.sv
module iq_pair_assembler_tb;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] busData = '0;
  logic txEnPin = 1'b0;
  logic cfgQFirst = 1'b0, cfgOffsetBin = 1'b0, cfgClkInvert = 1'b0;
  logic cfgClkEnable = 1'b1, cfgTxInvert = 1'b0, cfgHoldLast = 1'b0;
  logic         portClk, pairValid;
  logic [W-1:0] iOut, qOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [W-1:0] lastI = '0, lastQ = '0;

  always #5 clk = ~clk;

  iq_pair_assembler #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .busData(busData), .txEnPin(txEnPin),
    .cfgQFirst(cfgQFirst), .cfgOffsetBin(cfgOffsetBin), .cfgClkInvert(cfgClkInvert),
    .cfgClkEnable(cfgClkEnable), .cfgTxInvert(cfgTxInvert), .cfgHoldLast(cfgHoldLast),
    .portClk(portClk), .iOut(iOut), .qOut(qOut), .pairValid(pairValid)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] conv(input logic [W-1:0] w, input logic off);
    return off ? {~w[W-1], w[W-2:0]} : w;
  endfunction

  // R4, R5: expected port clock for the given phase under given settings
  function automatic logic expClk(input logic ph, input logic qf, input logic inv, input logic en);
    logic qOnBus;
    qOnBus = qf ? ~ph : ph;
    return en & (qOnBus ^ inv);
  endfunction

  task automatic stepTo();
    @(posedge clk); @(negedge clk);
  endtask

  // Change settings safely while idle (R6, R9)
  task automatic setCfg(input logic qf, off, inv, en, txi, hold);
    cfgQFirst = qf; cfgOffsetBin = off; cfgClkInvert = inv;
    cfgClkEnable = en; cfgHoldLast = hold;
    cfgTxInvert = txi;
    stepTo();
    txEnPin = txi;          // inactive under the new polarity
    stepTo();
  endtask

  // One pair with transmit held active; checks R1-R5
  task automatic sendPair(input logic [W-1:0] w1, input logic [W-1:0] w2);
    logic [W-1:0] eI, eQ;
    txEnPin = ~cfgTxInvert;
    busData = w1;
    check("R4 phase0 portClk", W'(portClk), W'(expClk(1'b0, cfgQFirst, cfgClkInvert, cfgClkEnable)));
    stepTo();
    check("R3 no valid mid-pair", W'(pairValid), W'(0));
    check("R4 phase1 portClk", W'(portClk), W'(expClk(1'b1, cfgQFirst, cfgClkInvert, cfgClkEnable)));
    busData = w2;
    stepTo();
    eI = cfgQFirst ? conv(w2, cfgOffsetBin) : conv(w1, cfgOffsetBin);
    eQ = cfgQFirst ? conv(w1, cfgOffsetBin) : conv(w2, cfgOffsetBin);
    check("R3 valid", W'(pairValid), W'(1));
    check("R1 R2 iOut", iOut, eI);
    check("R1 R2 qOut", qOut, eQ);
    lastI = eI; lastQ = eQ;
  endtask

  // R7: go idle and toggle the bus
  task automatic goIdleCheck();
    logic [W-1:0] eI, eQ;
    txEnPin = cfgTxInvert;
    busData = W'($urandom);
    stepTo();
    eI = cfgHoldLast ? lastI : '0;
    eQ = cfgHoldLast ? lastQ : '0;
    for (int k = 0; k < 2; k++) begin
      busData = W'($urandom);
      stepTo();
      check("R7 idle valid", W'(pairValid), W'(0));
      check("R7 idle iOut", iOut, eI);
      check("R7 idle qOut", qOut, eQ);
    end
    if (!cfgHoldLast) begin lastI = '0; lastQ = '0; end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 iOut", iOut, '0);
    check("R10 qOut", qOut, '0);
    check("R10 valid", W'(pairValid), W'(0));
    check("R10 phase via portClk", W'(portClk), W'(expClk(1'b0, 1'b0, 1'b0, 1'b1)));
  endtask

  task automatic t_allCombos();
    for (int c = 0; c < 32; c++) begin
      setCfg(c[0], c[1], c[2], 1'b1, c[3], c[4]);
      for (int p = 0; p < 3; p++) sendPair(W'($urandom), W'($urandom));
      goIdleCheck();   // R6 polarity exercised via cfgTxInvert
    end
  endtask

  task automatic t_clkDisable();
    setCfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 idle portClk low", W'(portClk), W'(0));
    sendPair(18'h12345, 18'h2abcd);
    sendPair(18'h00001, 18'h3ffff);
    goIdleCheck();
  endtask

  task automatic t_dropMidPair();
    setCfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    sendPair(18'h11111, 18'h22222);
    txEnPin = 1'b1; busData = 18'h0dead;  // first word only
    stepTo();
    txEnPin = 1'b0; busData = 18'h0beef;
    stepTo();
    check("R8 no valid after drop", W'(pairValid), W'(0));
    check("R8 hold kept I", iOut, 18'h11111);
    sendPair(18'h05555, 18'h0aaaa);       // must realign
    check("R8 realigned I", iOut, 18'h05555);
    goIdleCheck();
  endtask

  task automatic t_cfgMidPair();
    setCfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    txEnPin = 1'b1; busData = 18'h01234;
    stepTo();
    cfgQFirst = 1'b1; cfgOffsetBin = 1'b1; cfgClkInvert = 1'b1;
    check("R9 portClk keeps old cfg", W'(portClk), W'(expClk(1'b1, 1'b0, 1'b0, 1'b1)));
    busData = 18'h05678;
    stepTo();
    check("R9 pair valid", W'(pairValid), W'(1));
    check("R9 old order I", iOut, 18'h01234);
    check("R9 old order Q", qOut, 18'h05678);
    sendPair(18'h00abc, 18'h20def);  // new cfg applies at boundary
    check("R9 new order Q", qOut, 18'h20abc);
    goIdleCheck();
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_allCombos();
    t_clkDisable();
    t_dropMidPair();
    t_cfgMidPair();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule